// File: doc/BRIEF.md
# Accelerator Memory Access Permission Checker

This block guards the boundary between an untrusted accelerator's physically addressed caches and the trusted memory system. The accelerator presents requests one at a time on a valid/ready channel: a read, such as a line fill, or a write, such as a dirty-line eviction. The checker first compares the physical address with a window set by the host. Only if the address falls inside that window does it ask an external permission lookup port for the read and write bits of the 4 KB page that holds the address. A request that holds the right bit is passed to the memory side. For a read, the returned data is passed back to the accelerator. A request that fails the window test, or lacks the bit, is consumed and dropped. Nothing reaches memory, no data returns, and a fault interrupt is raised to the host.

The fault record keeps the address and direction of the first rejected request until the host clears it. While a fault is pending, the host may set a sticky lockout. After that, every later request is rejected without a lookup until the next reset. Execute rights play no part in the decision.

The controller is a single state machine with seven states. IDLE accepts a request. CHECK applies the window and lockout test. LOOKUP issues the page query. WAIT holds for the permission answer. FWD presents the request to memory. RDATA passes the read return back. DENY posts the fault. The transitions are:
- IDLE to CHECK on an accepted request.
- CHECK to DENY when the address is outside the window or the lockout is set; otherwise CHECK to LOOKUP.
- LOOKUP to WAIT when the lookup port is ready.
- WAIT to FWD when the answer grants the needed bit; otherwise WAIT to DENY.
- FWD to IDLE after a write is accepted by memory, or FWD to RDATA after a read is accepted.
- RDATA to IDLE on the read return.
- DENY to IDLE after one cycle.

Top module: `acc_perm_guard`

## Requirements
- R1: A read request (acc_req_write = 0) is forwarded to memory only when the lookup answers with perm_rd = 1 for its page. The forwarded address and direction equal the request's.
- R2: A write request (acc_req_write = 1) is forwarded to memory only when the lookup answers with perm_wr = 1. The forwarded address, direction and write data equal the request's.
- R3: An address is inside the window when win_lo <= address < win_hi, compared unsigned. An address outside the window is rejected, and no page lookup is issued for it.
- R4: The page number presented on lk_ppn equals the request address shifted right by 12 bits.
- R5: A rejected request never appears on the memory channel and never produces acc_rvalid. It sets fault_irq.
- R6: acc_rvalid is raised only while a forwarded read waits for its data, and then carries mem_rdata unchanged. A mem_rvalid pulse at any other time is dropped.
- R7: The fault record (fault_addr, fault_write) captures the first rejected request. Later rejections do not overwrite it while fault_irq is high.
- R8: fault_clr lowers fault_irq. A rejection in the same cycle as fault_clr is captured as the new fault.
- R9: host_lock asserted while fault_irq is high locks the block. Every later request is then rejected without a lookup until reset. host_lock asserted with no fault pending has no effect.
- R10: Requests are handled strictly one at a time: acc_req_ready is high only when no request is in progress. A lookup or memory request waiting for ready keeps its valid and payload stable.
- R11: After reset, fault_irq is low, acc_req_ready is high, and lk_req_valid, mem_valid and acc_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req_valid | input | 1 | Accelerator request valid |
| acc_req_ready | output | 1 | Checker can accept a request |
| acc_req_addr | input | AW | Physical address of the request |
| acc_req_write | input | 1 | 1 = write, 0 = read |
| acc_req_wdata | input | DW | Write data |
| acc_rvalid | output | 1 | Read data valid toward accelerator |
| acc_rdata | output | DW | Read data toward accelerator |
| win_lo | input | AW | Lowest legal address (inclusive) |
| win_hi | input | AW | Upper address limit (exclusive) |
| lk_req_valid | output | 1 | Page permission query valid |
| lk_req_ready | input | 1 | Lookup port accepts the query |
| lk_ppn | output | AW-12 | Physical page number queried |
| lk_rsp_valid | input | 1 | Permission answer valid |
| lk_rsp_rd | input | 1 | Page readable |
| lk_rsp_wr | input | 1 | Page writable |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Forwarded address |
| mem_write | output | 1 | Forwarded direction |
| mem_wdata | output | DW | Forwarded write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| fault_irq | output | 1 | Fault pending interrupt |
| fault_addr | output | AW | Address of the recorded fault |
| fault_write | output | 1 | Direction of the recorded fault |
| fault_clr | input | 1 | Host clears the fault record |
| host_lock | input | 1 | Host requests lockout (effective only while a fault is pending) |

## Verification
The hardest case to reach is a rejection landing in the same cycle as the host's clear. The rejection is posted two clock edges after a request is accepted, so the bench issues an out-of-window request while a fault is already pending. It then raises fault_clr exactly in the DENY cycle, counted from acceptance, and checks that the new address replaces the old. The lockout needs a pending fault first, so the bench pulses host_lock once with no fault to show it is ignored. Next it provokes a fault and locks the block. It then sends requests that the lookup would allow and checks that they are rejected with no query. Random addresses, directions, page permissions and ready stalls on both the lookup and memory sides cover the permitted and denied paths around these.

// File: rtl/apg_pkg.sv
package apg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_LOOKUP = 3'd2,
        ST_WAIT   = 3'd3,
        ST_FWD    = 3'd4,
        ST_RDATA  = 3'd5,
        ST_DENY   = 3'd6
    } apg_state_e;

    localparam int unsigned APG_PAGE_SHIFT = 12;

endpackage

// File: rtl/apg_window.sv
module apg_window #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          in_range
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= lo);
        below_hi = (addr < hi);
        in_range = above_lo && below_hi;
    end

endmodule

// File: rtl/apg_fault_rec.sv
module apg_fault_rec #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [AW-1:0] ev_addr,
    input  logic          ev_write,
    input  logic          clr,
    input  logic          lock_req,
    output logic          pend,
    output logic [AW-1:0] rec_addr,
    output logic          rec_write,
    output logic          locked
);

    logic take_new;

    always_comb begin
        take_new = ev_valid && (clr || !pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            rec_addr  <= '0;
            rec_write <= 1'b0;
        end else if (take_new) begin
            pend      <= 1'b1;
            rec_addr  <= ev_addr;
            rec_write <= ev_write;
        end else if (clr) begin
            pend      <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (lock_req && pend) begin
            locked <= 1'b1;
        end
    end

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(rec_addr) && $stable(rec_write))); // R7

    AST_CLR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev_valid) |=> (pend && rec_addr == $past(ev_addr))); // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R9

    AST_LOCK_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(pend)); // R9

endmodule

// File: rtl/apg_ctrl.sv
module apg_ctrl
    import apg_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    parameter int unsigned PS = APG_PAGE_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] cur_addr,
    input  logic          in_range,
    input  logic          locked,
    output logic          lk_valid,
    input  logic          lk_ready,
    output logic [AW-PS-1:0] lk_page,
    input  logic          rsp_valid,
    input  logic          rsp_rd,
    input  logic          rsp_wr,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [AW-1:0] m_addr,
    output logic          m_write,
    output logic [DW-1:0] m_wdata,
    input  logic          m_rvalid,
    input  logic [DW-1:0] m_rdata,
    output logic          deny_evt,
    output logic          deny_write
);

    apg_state_e state_q;
    apg_state_e state_d;
    logic          cur_write;
    logic [DW-1:0] cur_wdata;
    logic          perm_ok;
    logic          accept;

    always_comb begin
        accept  = req_valid && (state_q == ST_IDLE);
        perm_ok = cur_write ? rsp_wr : rsp_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_addr  <= req_addr;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (locked || !in_range) state_d = ST_DENY;
                else                     state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (lk_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) state_d = perm_ok ? ST_FWD : ST_DENY;
            end
            ST_FWD: begin
                if (m_ready) state_d = cur_write ? ST_IDLE : ST_RDATA;
            end
            ST_RDATA: begin
                if (m_rvalid) state_d = ST_IDLE;
            end
            ST_DENY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        lk_valid   = 1'b0;
        m_valid    = 1'b0;
        rvalid     = 1'b0;
        deny_evt   = 1'b0;
        lk_page    = cur_addr[AW-1:PS];
        m_addr     = cur_addr;
        m_write    = cur_write;
        m_wdata    = cur_wdata;
        rdata      = m_rdata;
        deny_write = cur_write;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_CHECK:  ;
            ST_LOOKUP: lk_valid  = 1'b1;
            ST_WAIT:   ;
            ST_FWD:    m_valid   = 1'b1;
            ST_RDATA:  rvalid    = m_rvalid;
            ST_DENY:   deny_evt  = 1'b1;
            default:   ;
        endcase
    end

    AST_NO_LOOKUP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> in_range); // R3

    AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_page))); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata))); // R10

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, lk_valid, m_valid, deny_evt})); // R10

    AST_LOCKED_NO_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && locked) |=> ##1 (!lk_valid && !m_valid)); // R9

    AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (!cur_write && m_rvalid)); // R6

endmodule

// File: rtl/acc_perm_guard.sv
module acc_perm_guard
    import apg_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    localparam int unsigned PW = AW - APG_PAGE_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req_valid,
    output logic          acc_req_ready,
    input  logic [AW-1:0] acc_req_addr,
    input  logic          acc_req_write,
    input  logic [DW-1:0] acc_req_wdata,
    output logic          acc_rvalid,
    output logic [DW-1:0] acc_rdata,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    output logic          lk_req_valid,
    input  logic          lk_req_ready,
    output logic [PW-1:0] lk_ppn,
    input  logic          lk_rsp_valid,
    input  logic          lk_rsp_rd,
    input  logic          lk_rsp_wr,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_write,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          fault_irq,
    output logic [AW-1:0] fault_addr,
    output logic          fault_write,
    input  logic          fault_clr,
    input  logic          host_lock
);

    logic [AW-1:0] cur_addr;
    logic          in_range;
    logic          locked;
    logic          deny_evt;
    logic          deny_write;

    apg_window #(.AW(AW)) u_window (
        .addr     (cur_addr),
        .lo       (win_lo),
        .hi       (win_hi),
        .in_range (in_range)
    );

    apg_ctrl #(.AW(AW), .DW(DW), .PS(APG_PAGE_SHIFT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (acc_req_valid),
        .req_ready  (acc_req_ready),
        .req_addr   (acc_req_addr),
        .req_write  (acc_req_write),
        .req_wdata  (acc_req_wdata),
        .rvalid     (acc_rvalid),
        .rdata      (acc_rdata),
        .cur_addr   (cur_addr),
        .in_range   (in_range),
        .locked     (locked),
        .lk_valid   (lk_req_valid),
        .lk_ready   (lk_req_ready),
        .lk_page    (lk_ppn),
        .rsp_valid  (lk_rsp_valid),
        .rsp_rd     (lk_rsp_rd),
        .rsp_wr     (lk_rsp_wr),
        .m_valid    (mem_valid),
        .m_ready    (mem_ready),
        .m_addr     (mem_addr),
        .m_write    (mem_write),
        .m_wdata    (mem_wdata),
        .m_rvalid   (mem_rvalid),
        .m_rdata    (mem_rdata),
        .deny_evt   (deny_evt),
        .deny_write (deny_write)
    );

    apg_fault_rec #(.AW(AW)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (deny_evt),
        .ev_addr   (cur_addr),
        .ev_write  (deny_write),
        .clr       (fault_clr),
        .lock_req  (host_lock),
        .pend      (fault_irq),
        .rec_addr  (fault_addr),
        .rec_write (fault_write),
        .locked    (locked)
    );

    AST_DENY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        deny_evt |=> fault_irq); // R5

    AST_FWD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr >= win_lo && mem_addr < win_hi)); // R3

endmodule

// File: tb/test_acc_perm_guard.sv
`timescale 1ns/1ps
module test_acc_perm_guard;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int PW = AW - 12;
    localparam logic [AW-1:0] LO = 32'h0001_0000;
    localparam logic [AW-1:0] HI = 32'h0080_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req_valid = 1'b0;
    logic          acc_req_ready;
    logic [AW-1:0] acc_req_addr = '0;
    logic          acc_req_write = 1'b0;
    logic [DW-1:0] acc_req_wdata = '0;
    logic          acc_rvalid;
    logic [DW-1:0] acc_rdata;
    logic [AW-1:0] win_lo = LO;
    logic [AW-1:0] win_hi = HI;
    logic          lk_req_valid;
    logic          lk_req_ready = 1'b0;
    logic [PW-1:0] lk_ppn;
    logic          lk_rsp_valid = 1'b0;
    logic          lk_rsp_rd = 1'b0;
    logic          lk_rsp_wr = 1'b0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_write;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          fault_irq;
    logic [AW-1:0] fault_addr;
    logic          fault_write;
    logic          fault_clr = 1'b0;
    logic          host_lock = 1'b0;

    int checks = 0;
    int fails = 0;

    logic          m_pend = 1'b0;
    logic [AW-1:0] m_faddr = '0;
    logic          m_fwr = 1'b0;
    logic          m_locked = 1'b0;

    always #5 clk = ~clk;

    acc_perm_guard #(.AW(AW), .DW(DW)) i_acc_perm_guard (
        .clk(clk), .rst_n(rst_n),
        .acc_req_valid(acc_req_valid), .acc_req_ready(acc_req_ready),
        .acc_req_addr(acc_req_addr), .acc_req_write(acc_req_write),
        .acc_req_wdata(acc_req_wdata), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
        .win_lo(win_lo), .win_hi(win_hi),
        .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready), .lk_ppn(lk_ppn),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_rd(lk_rsp_rd), .lk_rsp_wr(lk_rsp_wr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fault_irq(fault_irq), .fault_addr(fault_addr), .fault_write(fault_write),
        .fault_clr(fault_clr), .host_lock(host_lock)
    );

    function automatic logic page_rd(input logic [AW-1:0] a);
        return a[12] | a[14];
    endfunction

    function automatic logic page_wr(input logic [AW-1:0] a);
        return a[13] ^ a[15];
    endfunction

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_0F0F, ~a};
    endfunction

    function automatic logic in_win(input logic [AW-1:0] a);
        return (a >= LO) && (a < HI);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_deny(input logic [AW-1:0] a, input logic w);
        if (!m_pend) begin
            m_pend  = 1'b1;
            m_faddr = a;
            m_fwr   = w;
        end
    endtask

    task automatic check_fault(input string tag);
        chk(fault_irq == m_pend, tag, {63'd0, fault_irq}, {63'd0, m_pend});
        if (m_pend) begin
            chk(fault_addr == m_faddr, tag, {32'd0, fault_addr}, {32'd0, m_faddr});
            chk(fault_write == m_fwr, tag, {63'd0, fault_write}, {63'd0, m_fwr});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pend = 1'b0;
        m_locked = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_req(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input logic stalls);
        logic exp_lk, exp_ok, saw_lk, saw_fwd, saw_rd, rd_pend, rsp_pend, lk_held;
        logic [PW-1:0] held_ppn;
        saw_lk = 0; saw_fwd = 0; saw_rd = 0; rd_pend = 0; rsp_pend = 0; lk_held = 0;
        held_ppn = '0;
        exp_lk = in_win(a) && !m_locked;
        exp_ok = exp_lk && (w ? page_wr(a) : page_rd(a));
        @(negedge clk);
        chk(acc_req_ready == 1'b1, "R10 ready when idle", {63'd0, acc_req_ready}, 64'd1);
        acc_req_valid = 1'b1; acc_req_addr = a; acc_req_write = w; acc_req_wdata = d;
        @(posedge clk);
        #1 acc_req_valid = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            lk_req_ready = 0; lk_rsp_valid = 0; mem_ready = 0; mem_rvalid = 0;
            if (acc_req_ready) break;
            if (lk_held) begin
                chk(lk_req_valid && lk_ppn == held_ppn, "R10 lookup held", {63'd0, lk_req_valid}, 64'd1);
                lk_held = 0;
            end
            if (rsp_pend) begin
                lk_rsp_valid = 1; lk_rsp_rd = page_rd(a); lk_rsp_wr = page_wr(a);
                rsp_pend = 0;
            end
            if (lk_req_valid) begin
                if (!saw_lk) chk(lk_ppn == a[AW-1:12], "R4 page number", {44'd0, lk_ppn}, {44'd0, a[AW-1:12]});
                saw_lk = 1;
                if (stalls && ($urandom % 3 == 0)) begin
                    lk_held = 1; held_ppn = lk_ppn;
                end else begin
                    lk_req_ready = 1; rsp_pend = 1;
                end
            end
            if (mem_valid) begin
                if (!saw_fwd) begin
                    chk(mem_addr == a && mem_write == w, w ? "R2 fwd addr/dir" : "R1 fwd addr/dir",
                        {32'd0, mem_addr}, {32'd0, a});
                    if (w) chk(mem_wdata == d, "R2 fwd wdata", mem_wdata, d);
                end
                saw_fwd = 1;
                if (!(stalls && ($urandom % 3 == 0))) begin
                    mem_ready = 1;
                    rd_pend = !w;
                end
            end else if (rd_pend) begin
                mem_rvalid = 1; mem_rdata = mem_word(a);
                #1;
                chk(acc_rvalid == 1'b1, "R6 read return valid", {63'd0, acc_rvalid}, 64'd1);
                chk(acc_rdata == mem_word(a), "R6 read return data", acc_rdata, mem_word(a));
                saw_rd = 1; rd_pend = 0;
            end
        end
        chk(saw_lk == exp_lk, exp_lk ? "R4 lookup issued" : (m_locked ? "R9 no lookup when locked" : "R3 no lookup outside window"),
            {63'd0, saw_lk}, {63'd0, exp_lk});
        chk(saw_fwd == exp_ok, w ? "R2 write gating" : "R1 read gating", {63'd0, saw_fwd}, {63'd0, exp_ok});
        chk(saw_rd == (exp_ok && !w), "R5 no data for rejected/write", {63'd0, saw_rd}, {63'd0, exp_ok && !w});
        if (!exp_ok) model_deny(a, w);
        check_fault("R5 R7 fault record");
    endtask

    task automatic clear_fault();
        @(negedge clk);
        fault_clr = 1;
        @(negedge clk);
        fault_clr = 0;
        m_pend = 0;
        chk(fault_irq == 1'b0, "R8 clear lowers irq", {63'd0, fault_irq}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic w;
        void'($urandom(32'd1234));
        do_reset();
        // R11 reset state
        chk(fault_irq == 0, "R11 irq low", {63'd0, fault_irq}, 0);
        chk(acc_req_ready == 1, "R11 ready high", {63'd0, acc_req_ready}, 1);
        chk(!lk_req_valid && !mem_valid && !acc_rvalid, "R11 valids low",
            {61'd0, lk_req_valid, mem_valid, acc_rvalid}, 0);

        // R9: lock with no pending fault is ignored
        @(negedge clk); host_lock = 1; @(negedge clk); host_lock = 0;
        run_req(32'h0000_3000 + LO, 1'b0, '0, 1'b0);   // page rd=1 -> forwarded

        // R6 stray return while idle
        @(negedge clk); mem_rvalid = 1; mem_rdata = 64'hDEAD; #1;
        chk(acc_rvalid == 0, "R6 stray mem_rvalid dropped", {63'd0, acc_rvalid}, 0);
        @(negedge clk); mem_rvalid = 0;

        // R3 window edges
        run_req(LO, 1'b0, '0, 1'b0);
        run_req(LO - 1, 1'b0, '0, 1'b0);
        run_req(HI, 1'b1, 64'h11, 1'b0);
        // R7 second fault does not overwrite
        run_req(HI + 32'h100, 1'b0, '0, 1'b0);
        clear_fault();
        run_req(HI - 1, 1'b0, '0, 1'b0);
        run_req(32'h0000_2000 + LO, 1'b1, 64'hABCD, 1'b0); // wr bit set
        run_req(32'h0000_A000 + LO, 1'b1, 64'h1234, 1'b0); // wr bit clear -> deny

        // R8 clear in same cycle as a new rejection
        @(negedge clk);
        acc_req_valid = 1; acc_req_addr = 32'h0000_0040; acc_req_write = 1;
        @(posedge clk); #1 acc_req_valid = 0;
        @(posedge clk);
        @(negedge clk); fault_clr = 1;
        @(negedge clk); fault_clr = 0;
        chk(fault_irq == 1, "R8 same-cycle fault kept", {63'd0, fault_irq}, 1);
        chk(fault_addr == 32'h0000_0040, "R8 same-cycle fault addr", {32'd0, fault_addr}, 64'h40);
        m_pend = 1; m_faddr = 32'h0000_0040; m_fwr = 1;
        clear_fault();

        // random mix
        for (int n = 0; n < 300; n++) begin
            a = ($urandom % 8 == 0) ? $urandom : LO + ($urandom % (HI - LO));
            w = $urandom % 2;
            run_req(a, w, {$urandom, $urandom}, 1'b1);
            if ($urandom % 4 == 0 && m_pend) clear_fault();
        end

        // R9 lock: needs a pending fault
        if (!m_pend) run_req(HI, 1'b0, '0, 1'b0);
        @(negedge clk); host_lock = 1; @(negedge clk); host_lock = 0;
        m_locked = 1;
        run_req(32'h0000_3000 + LO, 1'b0, '0, 1'b0);
        clear_fault();
        run_req(32'h0000_2000 + LO, 1'b1, 64'h77, 1'b1);
        run_req(32'h0000_7000 + LO, 1'b0, '0, 1'b1);
        do_reset();
        run_req(32'h0000_3000 + LO, 1'b0, '0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule